// File: doc/BRIEF.md
# Call-Charge Tone Period Validator

This block decides whether a channel's squared-up comparator bit carries a call-charge tone at the selected system frequency. It counts cycles of a 3.579545 MHz reference clock between successive rising edges of the bit and compares each count against an acceptance window. A one-bit system select picks the window: 1 selects the 12 kHz system and 0 the 16 kHz system. The windows are set tighter than the band where a tone must not be detected, and wide enough to cover the band where it must be detected across the whole allowed reference clock range (3.558918 MHz to 3.589368 MHz).

A raw tone-valid flag is the only output, and it feeds a separate output mode controller. The flag rises only after a run of in-window periods. It falls after a short run of out-of-window periods, or when the bit stops toggling. Voice-band energy, up to 3.4 kHz, produces periods far longer than either window and never sets the flag. Each channel uses one instance. The incoming bit is assumed to be synchronised to the reference clock already.

Top module: `tonePeriodValidator`

## Requirements
- R1: With sysSel=1 (12 kHz system), a measured period of 291 to 306 reference clocks inclusive counts as in-window. 290 and 307 count as out-of-window.
- R2: With sysSel=0 (16 kHz system), a measured period of 218 to 230 reference clocks inclusive counts as in-window. 217 and 231 count as out-of-window. A 300-clock period is out-of-window in this mode.
- R3: A period is the number of reference clock rising edges from one sampled rising edge of toneIn (toneIn=1 after a sample of 0) to the next. toneValid goes to 1 on the clock edge that samples the rising edge ending the 8th consecutive in-window period. Any out-of-window period resets this run.
- R4: While toneValid is 1, a single out-of-window period leaves it at 1, and an in-window period resets the miss run. It goes to 0 on the clock edge that ends the 2nd consecutive out-of-window period.
- R5: If no rising edge arrives within 512 clocks of the last one, toneValid is cleared. The next rising edge only starts a new measurement and is not counted as a period.
- R6: Any change on sysSel clears toneValid at the next clock edge and discards the measurement in progress. The first rising edge after the change only starts a new measurement.
- R7: While rstN is low, toneValid is 0 and no measurement is running. After release, the first rising edge only starts a measurement.
- R8: A voice-band input (period of 1053 clocks, about 3.4 kHz) never sets toneValid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock, nominally 3.579545 MHz |
| rstN | input | 1 | Asynchronous active-low reset |
| toneIn | input | 1 | Synchronised comparator bit of the channel |
| sysSel | input | 1 | System select: 1 = 12 kHz, 0 = 16 kHz |
| toneValid | output | 1 | Raw tone-valid flag |

## Verification
The bench drives square waves whose rising edges are a chosen number of clocks apart. It uses the nominal tone periods of both systems and both sides of every window edge (290/291, 306/307, 217/218, 230/231), so an off-by-one in either bound shows up as the wrong flag. Runs of seven and eight good periods tell the rise threshold apart, and single and double misses tell the drop threshold apart. One bad period placed inside a good run checks that the good count restarts. Gaps of 1000 and 1053 clocks separate the silence timeout from ordinary rejection. A system-select change or a reset in the middle of a tone checks that the next edge only starts a new measurement.

// File: rtl/tonePeriodPkg.sv
package tonePeriodPkg;

  // control -> datapath
  typedef struct packed {
    logic restart;      // drop the running measurement
  } ctrlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic periodDone;   // a full period was measured this cycle
    logic inWindow;     // that period lies inside the selected window
    logic timeout;      // silence limit reached while a measurement ran
  } measStrobe_t;

endpackage

// File: rtl/periodMeter.sv
module periodMeter
  import tonePeriodPkg::*;
#(
  parameter int LO12    = 291,
  parameter int HI12    = 306,
  parameter int LO16    = 218,
  parameter int HI16    = 230,
  parameter int TIMEOUT = 512,
  localparam int CNT_W  = $clog2(TIMEOUT + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             toneIn,
  input  logic             sysSel,
  input  ctrlStrobe_t      ctrl,
  output measStrobe_t      meas,
  output logic [CNT_W-1:0] periodCnt
);

  localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(TIMEOUT);

  logic             prevBit;
  logic             armed;
  logic             risingEdge;
  logic [CNT_W-1:0] winLo;
  logic [CNT_W-1:0] winHi;

  assign risingEdge = toneIn && !prevBit;

  // window bounds picked by the system select
  always_comb begin
    if (sysSel) begin
      winLo = CNT_W'(LO12);
      winHi = CNT_W'(HI12);
    end else begin
      winLo = CNT_W'(LO16);
      winHi = CNT_W'(HI16);
    end
  end

  always_comb begin
    meas.periodDone = risingEdge && armed && !ctrl.restart;
    meas.inWindow   = (periodCnt >= winLo) && (periodCnt <= winHi);
    meas.timeout    = armed && !risingEdge && !ctrl.restart && (periodCnt == LIMIT_C);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevBit   <= 1'b0;
      armed     <= 1'b0;
      periodCnt <= '0;
    end else begin
      prevBit <= toneIn;
      if (ctrl.restart) begin
        armed     <= 1'b0;
        periodCnt <= '0;
      end else if (risingEdge) begin
        armed     <= 1'b1;
        periodCnt <= CNT_W'(1);
      end else begin
        if (periodCnt != LIMIT_C) periodCnt <= periodCnt + 1'b1;
        if (meas.timeout) armed <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/runTracker.sv
module runTracker
  import tonePeriodPkg::*;
#(
  parameter int ACCEPT_RUN = 8,
  parameter int REJECT_RUN = 2,
  localparam int GW = $clog2(ACCEPT_RUN + 1),
  localparam int BW = $clog2(REJECT_RUN + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sysSel,
  input  measStrobe_t meas,
  output ctrlStrobe_t ctrl,
  output logic        toneValid
);

  localparam logic [GW-1:0] GOOD_C = GW'(ACCEPT_RUN);
  localparam logic [BW-1:0] BAD_C  = BW'(REJECT_RUN);

  logic          sysSelPrev;
  logic [GW-1:0] goodRun;
  logic [BW-1:0] badRun;
  logic [GW-1:0] goodNext;
  logic [BW-1:0] badNext;

  assign ctrl.restart = (sysSel != sysSelPrev);
  assign goodNext = (goodRun == GOOD_C) ? goodRun : goodRun + 1'b1;
  assign badNext  = (badRun == BAD_C) ? badRun : badRun + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sysSelPrev <= 1'b0;
      goodRun    <= '0;
      badRun     <= '0;
      toneValid  <= 1'b0;
    end else begin
      sysSelPrev <= sysSel;
      if (ctrl.restart || meas.timeout) begin
        goodRun   <= '0;
        badRun    <= '0;
        toneValid <= 1'b0;
      end else if (meas.periodDone) begin
        if (meas.inWindow) begin
          goodRun <= goodNext;
          badRun  <= '0;
          if (goodNext == GOOD_C) toneValid <= 1'b1;
        end else begin
          badRun  <= badNext;
          goodRun <= '0;
          if (badNext == BAD_C) toneValid <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/tonePeriodValidator.sv
module tonePeriodValidator
  import tonePeriodPkg::*;
#(
  parameter int LO12       = 291,
  parameter int HI12       = 306,
  parameter int LO16       = 218,
  parameter int HI16       = 230,
  parameter int TIMEOUT    = 512,
  parameter int ACCEPT_RUN = 8,
  parameter int REJECT_RUN = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic toneIn,
  input  logic sysSel,
  output logic toneValid
);

  localparam int CNT_W = $clog2(TIMEOUT + 1);

  ctrlStrobe_t      ctrl;
  measStrobe_t      meas;
  logic [CNT_W-1:0] periodCnt;

  periodMeter #(
    .LO12(LO12), .HI12(HI12), .LO16(LO16), .HI16(HI16), .TIMEOUT(TIMEOUT)
  ) meter (
    .clk(clk), .rstN(rstN), .toneIn(toneIn), .sysSel(sysSel),
    .ctrl(ctrl), .meas(meas), .periodCnt(periodCnt)
  );

  runTracker #(
    .ACCEPT_RUN(ACCEPT_RUN), .REJECT_RUN(REJECT_RUN)
  ) tracker (
    .clk(clk), .rstN(rstN), .sysSel(sysSel),
    .meas(meas), .ctrl(ctrl), .toneValid(toneValid)
  );

endmodule

// File: rtl/tonePeriodValidatorChk.sv
module tonePeriodValidatorChk
  import tonePeriodPkg::*;
#(
  parameter int TIMEOUT = 512,
  localparam int CNT_W  = $clog2(TIMEOUT + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             toneValid,
  input measStrobe_t      meas,
  input ctrlStrobe_t      ctrl,
  input logic [CNT_W-1:0] periodCnt
);

  // R3
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(toneValid) |-> $past(meas.periodDone && meas.inWindow));

  // R4
  valid_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(toneValid) |-> $past(ctrl.restart || meas.timeout ||
                               (meas.periodDone && !meas.inWindow)));

  // R6
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.restart |=> !toneValid);

  // R5
  timeout_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    meas.timeout |=> !toneValid);

  // R5
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    periodCnt <= CNT_W'(TIMEOUT));

  // R7
  done_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(meas.periodDone && meas.timeout));

endmodule

bind tonePeriodValidator tonePeriodValidatorChk #(.TIMEOUT(TIMEOUT)) chkInst (
  .clk(clk), .rstN(rstN), .toneValid(toneValid),
  .meas(meas), .ctrl(ctrl), .periodCnt(periodCnt)
);

// File: tb/tonePeriodValidator_test.sv
module tonePeriodValidator_test;

  localparam int HIGH_LEN = 40;
  localparam int ROWS = 27;

  // each row: system select, edge spacing in clocks, number of edges, expected flag, requirement
  localparam int vSel[ROWS] = '{1,1,1,1,1,1,1,1,1,1,1,1,1,1,1,1,1,1,1, 0,0,0,0,0,0,0,0};
  localparam int vPer[ROWS] = '{300,300,330,300,330,330,291,307,306,290,290,300,290,300,300,
                                1000,300,300,1053, 224,224,300,218,231,230,217,217};
  localparam int vCnt[ROWS] = '{8,1,1,1,1,1,8,2,8,2,8,7,1,7,1, 1,7,1,10, 8,1,2,8,2,8,2,8};
  localparam int vExp[ROWS] = '{0,1,1,1,1,0,1,0,1,0,0,0,0,0,1, 0,0,1,0, 0,1,0,1,0,1,0,0};
  // tags: R3 rows 0,1,11-14; R4 rows 2-5; R1 rows 6-10; R5 rows 15-17; R8 row 18;
  // R6 row 19; R2 rows 20-26
  localparam int vReq[ROWS] = '{3,3,4,4,4,4,1,1,1,1,1,3,3,3,3, 5,5,5,8, 6,2,2,2,2,2,2,2};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic toneIn = 1'b0;
  logic sysSel = 1'b1;
  logic toneValid;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  tonePeriodValidator uut (
    .clk(clk), .rstN(rstN), .toneIn(toneIn), .sysSel(sysSel), .toneValid(toneValid)
  );

  always #10 clk = ~clk;

  always @(posedge clk) cycles <= cycles + 1;

  task automatic check(input logic actual, input logic expected, input int req, input string what);
    checks++;
    if (actual !== expected) begin
      fails++;
      $display("FAIL R%0d %s: toneValid=%0b expected=%0b", req, what, actual, expected);
    end
  endtask

  // rising edges exactly per clocks apart, high phase of HIGH_LEN clocks
  task automatic runTone(input int per, input int n);
    for (int i = 0; i < n; i++) begin
      toneIn = 1'b0;
      repeat (per - HIGH_LEN) @(negedge clk);
      toneIn = 1'b1;
      repeat (HIGH_LEN) @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired: cycles=%0d expected=<190000", cycles);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(toneValid, 1'b0, 7, "flag low in reset");        // R7
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(toneValid, 1'b0, 7, "flag low after release");   // R7

    for (int r = 0; r < ROWS; r++) begin
      sysSel = vSel[r][0];
      runTone(vPer[r], vCnt[r]);
      check(toneValid, vExp[r][0], vReq[r], $sformatf("row %0d period %0d", r, vPer[r]));
    end

    // R2: nine 224-clock periods after an armed edge
    runTone(224, 9);
    check(toneValid, 1'b1, 2, "16k nominal run");

    // R6: system change drops the flag at the next edge
    sysSel = 1'b1;
    @(negedge clk);
    check(toneValid, 1'b0, 6, "flag cleared by select change");
    runTone(300, 8);
    check(toneValid, 1'b0, 6, "first edge after change only arms");
    runTone(300, 1);
    check(toneValid, 1'b1, 6, "eighth period after change");

    // R7: reset in mid tone
    toneIn = 1'b0;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(toneValid, 1'b0, 7, "reset clears flag");
    rstN = 1'b1;
    runTone(300, 8);
    check(toneValid, 1'b0, 7, "first edge after reset only arms");
    runTone(300, 1);
    check(toneValid, 1'b1, 7, "eighth period after reset");

    summary();
    $finish;
  end

endmodule